// File: doc/BRIEF.md
# Dual-Plane Blink Display Controller

This block keeps two bytes of segment data for every digit of a multiplexed LED display, one byte in each of two memory planes (plane 0 and plane 1). A scanner outside the block presents a digit index each cycle, and the block returns the segment byte for that digit two cycles later. A global blink enable chooses the source plane. When blinking is off, plane 0 is always shown. When blinking is on, the planes take turns on the two phases of a blink clock. That clock is divided down from the oscillator that also clocks the block, so a segment whose two bits differ between the planes appears to flash.

Software writes the block through a byte-wide register port. The address selects the configuration register or a digit. For a digit, the address also picks plane 0, plane 1 or both planes. Two configuration bits arm one-shot actions that fire on the next chip-select rising edge. One clears the blink divider so that several devices can be brought into phase. The other empties both planes. Once it is configured, blinking runs with no further writes.

Top module: `blink_plane_ctrl`

## Requirements
- R1: After a synchronous reset, `seg_out` is 0x00 and `blink_phase` is 0. The configuration is all zero (shutdown, blink disabled, slow rate), and every digit of both planes reads as 0x00.
- R2: A write to a digit uses an address with bit 7 = 0, bits [4:0] = digit number below DIGITS, and bits [6:5] = 01 for plane 0 only, 10 for plane 1 only, 11 for both planes. Every other address except 0x04 is ignored, and so is target code 00.
- R3: Address 0x04 is the configuration register. Its bit 0 is the run bit. When the run bit is 0, `seg_out` is 0x00 whatever the plane contents.
- R4: Bit 3 of the configuration is the blink enable. When it is 0, `seg_out` shows the plane 0 byte whatever the blink phase.
- R5: The blink divider runs continuously. `blink_phase` toggles every SLOW_CYC cycles when configuration bit 2 is 0, and every FAST_CYC cycles when bit 2 is 1. With blink enabled, phase 0 shows plane 0 and phase 1 shows plane 1.
- R6: Writing configuration bit 4 = 1 arms a sync. On the next `cs_rise` pulse the divider count and `blink_phase` go to 0. The action happens once; later `cs_rise` pulses do nothing until the bit is written as 1 again.
- R7: Writing configuration bit 5 = 1 arms a clear. On the next `cs_rise` pulse every digit of both planes becomes 0x00 until it is rewritten. The action happens once per write.
- R8: The byte for the digit index sampled at one rising edge appears on `seg_out` after the second following edge. The read returns plane contents from before a write made at that same edge.
- R9: Configuration bits 1, 6 and 7 are stored nowhere and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; also the blink time base |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| cs_rise | input | 1 | One-cycle pulse marking a chip-select rising edge |
| digit_idx | input | IDXW | Digit currently selected by the scanner |
| seg_out | output | SEGW | Segment byte for the digit presented two cycles earlier |
| blink_phase | output | 1 | Current blink phase (0 selects plane 0) |

## Verification
A behavioural model in the bench predicts `seg_out` and `blink_phase` on every clock while the scanner walks all digits. The planes are loaded with distinct contents so that a byte from plane 0, a byte from plane 1, a cleared digit and a wrong digit all give different values. The bench scans with blink off, then at slow rate, then at fast rate. This separates the plane choice, the period selection and any wrong toggle point. Chip-select pulses are issued with and without an armed sync or clear, and writes go to malformed addresses and to the unused configuration bits, so that missing one-shot behaviour or a stray decode shows up as a wrong byte.

// File: rtl/blink_pkg.sv
package blink_pkg;
  localparam logic [7:0] CFG_ADDR = 8'h04;

  typedef struct packed {
    logic run;
    logic fast;
    logic blink_en;
  } disp_cfg_t;

  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_P0   = 2'b01,
    TGT_P1   = 2'b10,
    TGT_BOTH = 2'b11
  } plane_tgt_t;
endpackage

// File: rtl/blink_cfg.sv
module blink_cfg
  import blink_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_data,
  input  logic       cs_rise,
  output disp_cfg_t  cfg,
  output logic       sync_go,
  output logic       clear_go
);
  logic sync_pend, clear_pend;

  assign sync_go  = cs_rise & sync_pend;
  assign clear_go = cs_rise & clear_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg        <= '0;
      sync_pend  <= 1'b0;
      clear_pend <= 1'b0;
    end else if (cfg_wr) begin
      cfg.run    <= cfg_data[0];
      cfg.fast   <= cfg_data[2];
      cfg.blink_en <= cfg_data[3];
      sync_pend  <= cfg_data[4];
      clear_pend <= cfg_data[5];
    end else if (cs_rise) begin
      sync_pend  <= 1'b0;
      clear_pend <= 1'b0;
    end
  end

  AST_SYNC_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    (sync_go && !cfg_wr) |=> !sync_pend); // R6
  AST_CLEAR_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    (clear_go && !cfg_wr) |=> !clear_pend); // R7
endmodule

// File: rtl/blink_divider.sv
module blink_divider #(
  parameter int SLOW_CYC = 4000000,
  parameter int FAST_CYC = 2000000
) (
  input  logic clk,
  input  logic rst,
  input  logic fast,
  input  logic sync_go,
  output logic phase
);
  localparam int CNTW = $clog2(SLOW_CYC + 1);
  localparam logic [CNTW:0] SLOW_LIM = (CNTW+1)'(SLOW_CYC);
  localparam logic [CNTW:0] FAST_LIM = (CNTW+1)'(FAST_CYC);

  logic [CNTW-1:0] cnt;
  logic [CNTW:0]   lim, nxt;

  assign lim = fast ? FAST_LIM : SLOW_LIM;
  assign nxt = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || sync_go) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (nxt >= lim) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cnt} < SLOW_LIM); // R5
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sync_go && nxt < lim) |=> $stable(phase)); // R5
  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sync_go |=> (cnt == '0 && !phase)); // R6
endmodule

// File: rtl/plane_store.sv
module plane_store #(
  parameter int DIGITS = 8,
  parameter int SEGW   = 8,
  localparam int IDXW  = $clog2(DIGITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           wr_plane,
  input  logic [IDXW-1:0]      wr_idx,
  input  logic [SEGW-1:0]      wr_data,
  input  logic                 clear,
  input  logic [IDXW-1:0]      rd_idx,
  output logic [1:0][SEGW-1:0] rd_data,
  output logic [1:0]           rd_vld
);
  for (genvar p = 0; p < 2; p++) begin : g_plane
    logic [SEGW-1:0] mem [DIGITS];
    logic [DIGITS-1:0] vld;

    always_ff @(posedge clk) begin
      if (wr_plane[p]) mem[wr_idx] <= wr_data;
      rd_data[p] <= mem[rd_idx];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld       <= '0;
        rd_vld[p] <= 1'b0;
      end else begin
        rd_vld[p] <= vld[rd_idx];
        if (clear) vld <= '0;
        if (wr_plane[p]) vld[wr_idx] <= 1'b1;
      end
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
      (clear && !wr_plane[p]) |=> (vld == '0)); // R7
  end
endmodule

// File: rtl/blink_plane_ctrl.sv
module blink_plane_ctrl
  import blink_pkg::*;
#(
  parameter int DIGITS   = 8,
  parameter int SEGW     = 8,
  parameter int SLOW_CYC = 4000000,
  parameter int FAST_CYC = 2000000,
  localparam int IDXW    = $clog2(DIGITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [7:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic            cs_rise,
  input  logic [IDXW-1:0] digit_idx,
  output logic [SEGW-1:0] seg_out,
  output logic            blink_phase
);
  disp_cfg_t  cfg;
  plane_tgt_t tgt;
  logic       cfg_wr, dig_ok, sync_go, clear_go;
  logic [1:0] wr_plane;
  logic [1:0][SEGW-1:0] rd_data;
  logic [1:0] rd_vld;
  logic       on_q, sel_q;
  logic [SEGW-1:0] pick;

  assign cfg_wr   = wr_en && (wr_addr == CFG_ADDR);
  assign tgt      = plane_tgt_t'(wr_addr[6:5]);
  assign dig_ok   = wr_en && !wr_addr[7] && (int'(wr_addr[4:0]) < DIGITS);
  assign wr_plane = dig_ok ? wr_addr[6:5] : 2'b00;

  blink_cfg u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(wr_data),
    .cs_rise(cs_rise), .cfg(cfg), .sync_go(sync_go), .clear_go(clear_go)
  );

  blink_divider #(.SLOW_CYC(SLOW_CYC), .FAST_CYC(FAST_CYC)) u_div (
    .clk(clk), .rst(rst), .fast(cfg.fast), .sync_go(sync_go),
    .phase(blink_phase)
  );

  plane_store #(.DIGITS(DIGITS), .SEGW(SEGW)) u_store (
    .clk(clk), .rst(rst), .wr_plane(wr_plane),
    .wr_idx(wr_addr[IDXW-1:0]), .wr_data(wr_data[SEGW-1:0]),
    .clear(clear_go), .rd_idx(digit_idx),
    .rd_data(rd_data), .rd_vld(rd_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q  <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      on_q  <= cfg.run;
      sel_q <= cfg.blink_en & blink_phase;
    end
  end

  always_comb begin
    if (sel_q) pick = rd_vld[1] ? rd_data[1] : '0;
    else       pick = rd_vld[0] ? rd_data[0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) seg_out <= '0;
    else     seg_out <= on_q ? pick : '0;
  end

  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !on_q |=> (seg_out == '0)); // R3
  AST_NO_P1_WHEN_STEADY: assert property (@(posedge clk) disable iff (rst)
    !cfg.blink_en |=> !sel_q); // R4
  AST_TGT_NONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (tgt == TGT_NONE) |-> (wr_plane == 2'b00)); // R2
endmodule

// File: tb/blink_plane_ctrl_tb.sv
module blink_plane_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW = 24;
  localparam int FAST = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic cs_rise = 1'b0;
  logic [2:0] digit_idx = '0;
  logic [7:0] seg_out;
  logic blink_phase;

  blink_plane_ctrl #(.SLOW_CYC(SLOW), .FAST_CYC(FAST)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cs_rise(cs_rise), .digit_idx(digit_idx),
    .seg_out(seg_out), .blink_phase(blink_phase)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) digit_idx <= digit_idx + 3'd1;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit primed = 0;

  // reference model state
  int m0 [8];
  int m1 [8];
  bit s_run, s_fast, s_blk, p_sync, p_clr, ph;
  int cnt;
  int q0, q1;

  always @(negedge clk) begin
    int exp_now, lim;
    cycles++;
    if (primed) begin
      checks++;
      if (seg_out !== 8'(q1)) begin
        fails++;
        $display("FAIL %s seg_out got %h expected %h", cur_req, seg_out, 8'(q1));
      end
      checks++;
      if (blink_phase !== ph) begin
        fails++;
        $display("FAIL %s blink_phase got %b expected %b", cur_req, blink_phase, ph);
      end
    end
    exp_now = !s_run ? 0 : ((s_blk && ph) ? m1[digit_idx] : m0[digit_idx]);
    q1 = q0; q0 = exp_now;
    if (rst) begin
      primed = 1;
      q0 = 0; q1 = 0;
      foreach (m0[i]) begin m0[i] = 0; m1[i] = 0; end
      s_run = 0; s_fast = 0; s_blk = 0; p_sync = 0; p_clr = 0; ph = 0; cnt = 0;
    end else begin
      lim = s_fast ? FAST : SLOW;
      if (cs_rise && p_sync) begin cnt = 0; ph = 0; end
      else if (cnt + 1 >= lim) begin cnt = 0; ph = !ph; end
      else cnt++;
      if (cs_rise && p_clr) foreach (m0[i]) begin m0[i] = 0; m1[i] = 0; end
      if (wr_en && !wr_addr[7] && wr_addr[4:3] == 2'b00) begin
        if (wr_addr[5]) m0[wr_addr[2:0]] = wr_data;
        if (wr_addr[6]) m1[wr_addr[2:0]] = wr_data;
      end
      if (wr_en && wr_addr == 8'h04) begin
        s_run = wr_data[0]; s_fast = wr_data[2]; s_blk = wr_data[3];
        p_sync = wr_data[4]; p_clr = wr_data[5];
      end else if (cs_rise) begin
        p_sync = 0; p_clr = 0;
      end
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired got %0d cycles expected under 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic cs_pulse();
    cs_rise = 1'b1;
    step(1);
    cs_rise = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    cur_req = "R1"; step(6);
    wr(8'h04, 8'h01);            // run, blink off: planes still empty
    step(10);
    cur_req = "R2";
    for (int d = 0; d < 8; d++) wr(8'h20 + 8'(d), 8'h10 + 8'(d));
    for (int d = 0; d < 8; d++) wr(8'h40 + 8'(d), 8'hA0 + 8'(d));
    wr(8'h67, 8'h5A);            // both planes, digit 7
    wr(8'h85, 8'hFF);            // bit 7 set: ignored
    wr(8'h2D, 8'hEE);            // digit field out of range: ignored
    wr(8'h03, 8'h77);            // target none: ignored
    cur_req = "R4"; step(60);
    cur_req = "R5"; wr(8'h09, 8'h09); step(80);   // not the cfg address
    wr(8'h04, 8'h09); step(80);
    wr(8'h04, 8'h0D); step(50);
    cur_req = "R8"; wr(8'h23, 8'h3C); wr(8'h43, 8'hC3); step(30);
    cur_req = "R6";
    step(3); wr(8'h04, 8'h19); step(4); cs_pulse(); step(7);
    cs_pulse(); step(20);                          // one-shot: no effect
    cur_req = "R7";
    wr(8'h04, 8'h29); step(5); cs_pulse(); step(20);
    wr(8'h61, 8'h81); step(16);
    wr(8'h04, 8'h09); cs_pulse(); step(16);        // not re-armed
    cur_req = "R3"; wr(8'h04, 8'h08); step(30);
    cur_req = "R9"; wr(8'h04, 8'hCB); step(40);
    wr(8'h04, 8'hC2); step(20);
    cur_req = "R1"; rst = 1'b1; step(2); rst = 1'b0; step(12);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule